// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the raster timing for a video output. It counts samples along each line and lines within each field. From those counts it derives an active-video flag, a field indicator, horizontal and vertical sync pulses, and strobes that mark the start of each frame and of each active line. The downstream pixel logic uses these signals to know when to present data. Software or a neighbouring block supplies the programmable timing values: the active sample count per line, the horizontal front porch, the active line counts for the two fields, and an interlaced select. The horizontal sync width, the horizontal back porch and the vertical blanking are fixed by parameters.

Each line is laid out as the active samples, then the front porch, then the sync pulse, then the back porch. Each field is laid out as its active lines followed by the blanking lines. In progressive mode every field is field 0 and uses the field-0 line count. In interlaced mode field 0 and field 1 alternate, and each uses its own line count. The block samples the programmable values only at the start of a frame and while reset is held, so one frame never mixes two timings.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `hCount` and `vCount` are 0 and `fieldId` is 0. Reset is synchronous to `clk`, and it loads the programmable inputs as the timing for the first frame.
- R2: A line lasts W + FP + HSYNC_W + HBACK_W cycles, where W is the active width and FP is the front porch. `hCount` runs from 0 up to that total minus 1 and then returns to 0.
- R3: `activeVideo` is 1 exactly when `hCount` < W and `vCount` < L, where L is the active line count of the current field.
- R4: `hSync` is 1 for HSYNC_W cycles starting at `hCount` = W + FP, so the front porch follows the active samples on every line, blank lines included.
- R5: A field lasts L + VBLANK_LINES lines. `vCount` advances only when a line ends, and it returns to 0 at the end of the field. `vSync` is 1 on lines L through L + VSYNC_LINES - 1.
- R6: With the interlaced input at 0 (progressive), `fieldId` stays 0, every field uses the field-0 line count, and the field-1 line count has no effect on any output.
- R7: With the interlaced input at 1, `fieldId` changes value at the end of every field, and field 1 (`fieldId` = 1) uses the field-1 line count. `fieldId` changes only in the cycle where both counters return to 0.
- R8: `sofStrobe` is 1 for a single cycle, at `hCount` = 0 and `vCount` = 0 of field 0. `solStrobe` is 1 at `hCount` = 0 of each active line, in both fields.
- R9: A change to any programmable input takes effect only at the next start of field 0. A change made partway through a frame, including during field 0 of an interlaced frame, leaves the rest of that frame (both of its fields) on the old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgInterlaced | input | 1 | 1 selects interlaced operation, 0 selects progressive |
| cfgActiveWidth | input | CNT_W | Active samples per line (at least 1) |
| cfgF0Lines | input | CNT_W | Active lines of field 0, or of the whole frame in progressive mode (at least 1) |
| cfgF1Lines | input | CNT_W | Active lines of field 1, used only in interlaced mode (at least 1) |
| cfgFrontPorch | input | CNT_W | Horizontal front porch in samples |
| hCount | output | CNT_W+2 | Sample position within the line |
| vCount | output | CNT_W+2 | Line position within the field |
| activeVideo | output | 1 | Current sample lies inside the active picture |
| fieldId | output | 1 | Current field, 0 or 1 |
| sofStrobe | output | 1 | First active sample of field 0 |
| solStrobe | output | 1 | First sample of each active line |
| hSync | output | 1 | Horizontal sync pulse, active high |
| vSync | output | 1 | Vertical sync pulse, active high |

## Verification
Every output is decoded directly from the counter and field registers. Each output is therefore valid in the same cycle as the counter values it describes, and a result appears one clock edge after the state that produces it. A programmable input acts only at the edge that ends a frame, which is the last sample of the last line of field 0 in progressive mode or of field 1 in interlaced mode. The scoreboard therefore expects a new timing starting with the first item of the following frame. The bench builds a per-cycle list of the expected values for each frame from the timing values in force for that frame. It compares one list entry at every falling edge, starting with the reset-state cycle. This keeps each comparison half a cycle away from the edge that updates the counters, and a changed input is never expected to show before its frame boundary.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Events the counter datapath reports to the field/config control.
  typedef struct packed {
    logic lineEnd;   // last sample of a line
    logic fieldEnd;  // last sample of the last line of a field
  } rtgEvents_t;

endpackage

// File: rtl/rtg_control.sv
module rtg_control #(
  parameter int CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgInterlaced,
  input  logic [CNT_W-1:0]     cfgActiveWidth,
  input  logic [CNT_W-1:0]     cfgF0Lines,
  input  logic [CNT_W-1:0]     cfgF1Lines,
  input  logic [CNT_W-1:0]     cfgFrontPorch,
  input  rtg_pkg::rtgEvents_t  events,
  output logic [CNT_W-1:0]     curWidth,
  output logic [CNT_W-1:0]     curLines,
  output logic [CNT_W-1:0]     curFrontPorch,
  output logic                 fieldId
);

  logic             shInterlaced;
  logic [CNT_W-1:0] shWidth;
  logic [CNT_W-1:0] shF0Lines;
  logic [CNT_W-1:0] shF1Lines;
  logic [CNT_W-1:0] shFrontPorch;
  logic             nextField;
  logic             loadNow;

  // Field sequencing: progressive always returns to field 0.
  always_comb begin
    nextField = shInterlaced ? ~fieldId : 1'b0;
    loadNow   = events.fieldEnd && !nextField;
  end

  // Shadow set: captured in reset and at each frame boundary only.
  always_ff @(posedge clk) begin
    if (!rstN || loadNow) begin
      shInterlaced <= cfgInterlaced;
      shWidth      <= cfgActiveWidth;
      shF0Lines    <= cfgF0Lines;
      shF1Lines    <= cfgF1Lines;
      shFrontPorch <= cfgFrontPorch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldId <= 1'b0;
    end else if (events.fieldEnd) begin
      fieldId <= nextField;
    end
  end

  assign curWidth      = shWidth;
  assign curFrontPorch = shFrontPorch;
  assign curLines      = fieldId ? shF1Lines : shF0Lines;

endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath #(
  parameter int CNT_W        = 12,
  parameter int HSYNC_W      = 3,
  parameter int HBACK_W      = 2,
  parameter int VBLANK_LINES = 3,
  parameter int VSYNC_LINES  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     curWidth,
  input  logic [CNT_W-1:0]     curLines,
  input  logic [CNT_W-1:0]     curFrontPorch,
  input  logic                 fieldId,
  output logic [CNT_W+1:0]     hCount,
  output logic [CNT_W+1:0]     vCount,
  output rtg_pkg::rtgEvents_t  events,
  output logic                 activeVideo,
  output logic                 sofStrobe,
  output logic                 solStrobe,
  output logic                 hSync,
  output logic                 vSync
);

  localparam int CW = CNT_W + 2;

  logic [CW-1:0] widthW;
  logic [CW-1:0] linesW;
  logic [CW-1:0] syncStart;
  logic [CW-1:0] syncStop;
  logic [CW-1:0] lineLast;
  logic [CW-1:0] fieldLast;
  logic          hInActive;
  logic          vInActive;

  always_comb begin
    widthW    = CW'(curWidth);
    linesW    = CW'(curLines);
    syncStart = widthW + CW'(curFrontPorch);
    syncStop  = syncStart + CW'(HSYNC_W);
    lineLast  = syncStop + CW'(HBACK_W) - CW'(1);
    fieldLast = linesW + CW'(VBLANK_LINES) - CW'(1);
  end

  always_comb begin
    events.lineEnd  = (hCount == lineLast);
    events.fieldEnd = events.lineEnd && (vCount == fieldLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (events.lineEnd) begin
      hCount <= '0;
      vCount <= events.fieldEnd ? '0 : vCount + CW'(1);
    end else begin
      hCount <= hCount + CW'(1);
    end
  end

  always_comb begin
    hInActive   = (hCount < widthW);
    vInActive   = (vCount < linesW);
    activeVideo = hInActive && vInActive;
    solStrobe   = (hCount == '0) && vInActive;
    sofStrobe   = (hCount == '0) && (vCount == '0) && !fieldId;
    hSync       = (hCount >= syncStart) && (hCount < syncStop);
  end

  generate
    if (VSYNC_LINES > 0) begin : g_vsync
      assign vSync = (vCount >= linesW) && (vCount < linesW + CW'(VSYNC_LINES));
    end else begin : g_novsync
      assign vSync = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int CNT_W        = 12,
  parameter int HSYNC_W      = 3,
  parameter int HBACK_W      = 2,
  parameter int VBLANK_LINES = 3,
  parameter int VSYNC_LINES  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgInterlaced,
  input  logic [CNT_W-1:0]   cfgActiveWidth,
  input  logic [CNT_W-1:0]   cfgF0Lines,
  input  logic [CNT_W-1:0]   cfgF1Lines,
  input  logic [CNT_W-1:0]   cfgFrontPorch,
  output logic [CNT_W+1:0]   hCount,
  output logic [CNT_W+1:0]   vCount,
  output logic               activeVideo,
  output logic               fieldId,
  output logic               sofStrobe,
  output logic               solStrobe,
  output logic               hSync,
  output logic               vSync
);

  rtg_pkg::rtgEvents_t events;
  logic [CNT_W-1:0]    curWidth;
  logic [CNT_W-1:0]    curLines;
  logic [CNT_W-1:0]    curFrontPorch;

  rtg_control #(.CNT_W(CNT_W)) ctrlI (
    .clk            (clk),
    .rstN           (rstN),
    .cfgInterlaced  (cfgInterlaced),
    .cfgActiveWidth (cfgActiveWidth),
    .cfgF0Lines     (cfgF0Lines),
    .cfgF1Lines     (cfgF1Lines),
    .cfgFrontPorch  (cfgFrontPorch),
    .events         (events),
    .curWidth       (curWidth),
    .curLines       (curLines),
    .curFrontPorch  (curFrontPorch),
    .fieldId        (fieldId)
  );

  rtg_datapath #(
    .CNT_W        (CNT_W),
    .HSYNC_W      (HSYNC_W),
    .HBACK_W      (HBACK_W),
    .VBLANK_LINES (VBLANK_LINES),
    .VSYNC_LINES  (VSYNC_LINES)
  ) dpI (
    .clk           (clk),
    .rstN          (rstN),
    .curWidth      (curWidth),
    .curLines      (curLines),
    .curFrontPorch (curFrontPorch),
    .fieldId       (fieldId),
    .hCount        (hCount),
    .vCount        (vCount),
    .events        (events),
    .activeVideo   (activeVideo),
    .sofStrobe     (sofStrobe),
    .solStrobe     (solStrobe),
    .hSync         (hSync),
    .vSync         (vSync)
  );

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W+1:0] hCount,
  input logic [CNT_W+1:0] vCount,
  input logic             activeVideo,
  input logic             fieldId,
  input logic             sofStrobe,
  input logic             hSync,
  input logic             vSync
);

  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hCount != '0) |-> (hCount == $past(hCount) + 1'b1));

  // R5
  v_at_line_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vCount) |-> (hCount == '0));

  // R7
  field_at_frame_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldId) |-> (hCount == '0 && vCount == '0));

  // R8
  sof_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofStrobe |=> !sofStrobe);

  // R8
  sof_in_picture_chk: assert property (@(posedge clk) disable iff (!rstN)
    sofStrobe |-> (activeVideo && !fieldId));

  // R4
  hsync_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    hSync |-> !activeVideo);

  // R5
  vsync_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> !activeVideo);

endmodule

bind raster_timing_gen rtg_checker #(.CNT_W(CNT_W)) chkI (
  .clk         (clk),
  .rstN        (rstN),
  .hCount      (hCount),
  .vCount      (vCount),
  .activeVideo (activeVideo),
  .fieldId     (fieldId),
  .sofStrobe   (sofStrobe),
  .hSync       (hSync),
  .vSync       (vSync)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb_top;

  localparam int CNT_W   = 12;
  localparam int HS_W    = 3;
  localparam int HB_W    = 2;
  localparam int VB      = 3;
  localparam int VS      = 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgInterlaced = 1'b0;
  logic [CNT_W-1:0] cfgActiveWidth = '0;
  logic [CNT_W-1:0] cfgF0Lines = '0;
  logic [CNT_W-1:0] cfgF1Lines = '0;
  logic [CNT_W-1:0] cfgFrontPorch = '0;
  logic [CNT_W+1:0] hCount;
  logic [CNT_W+1:0] vCount;
  logic             activeVideo;
  logic             fieldId;
  logic             sofStrobe;
  logic             solStrobe;
  logic             hSync;
  logic             vSync;

  always #4 clk = ~clk;  // 125 MHz

  raster_timing_gen dut_i (
    .clk(clk), .rstN(rstN), .cfgInterlaced(cfgInterlaced),
    .cfgActiveWidth(cfgActiveWidth), .cfgF0Lines(cfgF0Lines),
    .cfgF1Lines(cfgF1Lines), .cfgFrontPorch(cfgFrontPorch),
    .hCount(hCount), .vCount(vCount), .activeVideo(activeVideo),
    .fieldId(fieldId), .sofStrobe(sofStrobe), .solStrobe(solStrobe),
    .hSync(hSync), .vSync(vSync)
  );

  typedef struct {
    int h;
    int v;
    bit act;
    bit fld;
    bit sof;
    bit sol;
    bit hs;
    bit vs;
    bit il;
    bit lateCfg;
  } expItem_t;

  expItem_t expQ[$];
  int  testsRun = 0;
  int  testsFailed = 0;
  int  itemNo = 0;
  bit  monEn = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp, input int idx);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s at item %0d: actual %0d expected %0d", req, what, idx, act, exp);
    end
  endtask

  // Driver side: expected per-cycle items for one whole frame.
  task automatic pushFrame(input bit il, input int w, input int l0, input int l1,
                           input int fp, input bit lateCfg);
    int lineLen;
    lineLen = w + fp + HS_W + HB_W;
    for (int f = 0; f <= (il ? 1 : 0); f++) begin
      int lines;
      lines = (f == 1) ? l1 : l0;
      for (int v = 0; v < lines + VB; v++) begin
        for (int h = 0; h < lineLen; h++) begin
          expItem_t it;
          it.h   = h;
          it.v   = v;
          it.act = (h < w) && (v < lines);
          it.fld = (f == 1);
          it.sof = (h == 0) && (v == 0) && (f == 0);
          it.sol = (h == 0) && (v < lines);
          it.hs  = (h >= w + fp) && (h < w + fp + HS_W);
          it.vs  = (v >= lines) && (v < lines + VS);
          it.il  = il;
          it.lateCfg = lateCfg;
          expQ.push_back(it);
        end
      end
    end
  endtask

  // Monitor: one comparison set per cycle, at the falling edge.
  always @(negedge clk) begin
    if (monEn && expQ.size() > 0) begin
      expItem_t e;
      string fReq;
      string gReq;
      e = expQ.pop_front();
      fReq = e.il ? "R7" : "R6";
      gReq = e.lateCfg ? "R9" : "R2";
      if (itemNo == 0) begin
        check("R1", "hCount after reset", int'(hCount), 0, itemNo);
        check("R1", "vCount after reset", int'(vCount), 0, itemNo);
        check("R1", "fieldId after reset", int'(fieldId), 0, itemNo);
      end
      check(gReq, "hCount", int'(hCount), e.h, itemNo);
      check(e.lateCfg ? "R9" : "R5", "vCount", int'(vCount), e.v, itemNo);
      check("R3", "activeVideo", int'(activeVideo), int'(e.act), itemNo);
      check(fReq, "fieldId", int'(fieldId), int'(e.fld), itemNo);
      check("R8", "sofStrobe", int'(sofStrobe), int'(e.sof), itemNo);
      check("R8", "solStrobe", int'(solStrobe), int'(e.sol), itemNo);
      check("R4", "hSync", int'(hSync), int'(e.hs), itemNo);
      check("R5", "vSync", int'(vSync), int'(e.vs), itemNo);
      itemNo++;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired after %0d items", itemNo);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : driver
    // Frame A: progressive, field-1 count set but must be ignored (R6).
    cfgInterlaced  = 1'b0;
    cfgActiveWidth = 12'd8;
    cfgF0Lines     = 12'd4;
    cfgF1Lines     = 12'd9;
    cfgFrontPorch  = 12'd2;
    pushFrame(1'b0, 8, 4, 9, 2, 1'b0);            // 105 cycles
    pushFrame(1'b1, 6, 3, 2, 3, 1'b1);            // frame B, 154 cycles
    pushFrame(1'b1, 6, 3, 2, 3, 1'b1);            // frame B again
    pushFrame(1'b0, 10, 2, 7, 1, 1'b1);           // frame C, 80 cycles
    repeat (3) @(posedge clk);
    @(posedge clk);
    #1;
    rstN  = 1'b1;
    monEn = 1'b1;
    // R9: switch to interlaced B in the middle of frame A.
    repeat (20) @(negedge clk);
    cfgInterlaced  = 1'b1;
    cfgActiveWidth = 12'd6;
    cfgF0Lines     = 12'd3;
    cfgF1Lines     = 12'd2;
    cfgFrontPorch  = 12'd3;
    // R9: switch to C during field 0 of the second B frame.
    repeat (105 + 154 + 40 - 20) @(negedge clk);
    cfgInterlaced  = 1'b0;
    cfgActiveWidth = 12'd10;
    cfgF0Lines     = 12'd2;
    cfgF1Lines     = 12'd7;
    cfgFrontPorch  = 12'd1;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule